// File: doc/BRIEF.md
# Selectable-Characteristic Word-Length Reducer

This block shortens a two's-complement sample of `IN_W` bits to a narrower word of `OUT_W` bits, dropping `IN_W - OUT_W` low-order bits. A small configuration register picks how the discarded bits are disposed of. There are four ways:
- round-to-nearest, which gives a characteristic with a zero level;
- floor, which gives an offset characteristic;
- midriser, which is floor plus an extra forced-one LSB, so it is symmetric and has no zero level;
- truncation of the magnitude toward zero, where the sign is put back afterwards.

Results that fall outside the output range are clipped to the nearer limit instead of wrapping. An option bit removes the most negative code so that the clipped range is symmetric.

A sample enters with `inValid`. Exactly one clock later the result appears on `outWord` with `outValid`, and `outOvf` is raised if the value had to be clipped. The output word is always `OUT_W + 1` bits wide. The midriser mode needs that extra bit. The other modes present their `OUT_W`-bit result sign-extended into it.

Top module: `qz_top`

## Requirements
- R1: While reset is asserted and after it is released with no input, `outValid`, `outOvf` and `outWord` are all zero.
- R2: For each cycle with `inValid` high, `outValid` is high in the next cycle. `outOvf` is never high while `outValid` is low.
- R3: Mode 0 (round) yields floor((x + 2^(D-1)) / 2^D), where D = IN_W-OUT_W. An exact half-step tie therefore moves toward positive infinity.
- R4: Mode 1 (floor) yields the largest integer not exceeding x / 2^D.
- R5: Mode 2 (midriser) yields 2*floor(x / 2^D) + 1 over all `OUT_W+1` bits. Bit 0 of the output is always 1, and zero is never produced.
- R6: Mode 3 (magnitude truncation) truncates |x| / 2^D toward zero and then restores the sign. Every input in -(2^D - 1) .. 2^D - 1 maps to 0.
- R7: In modes 0, 1 and 3 the result is clipped to the range -2^(OUT_W-1) .. 2^(OUT_W-1)-1. `outOvf` is high exactly on output samples whose value was changed by clipping.
- R8: When the symmetric option is set, the lower limit in modes 0, 1 and 3 becomes -(2^(OUT_W-1)-1), and a sample clipped by this rule raises `outOvf`. In mode 2 the option has no effect.
- R9: In modes 0, 1 and 3 the `OUT_W`-bit result is sign-extended into the `OUT_W+1`-bit `outWord`.
- R10: `cfgMode` and `cfgSym` are loaded only in a cycle with `cfgWe` high. They govern the samples accepted from the next cycle on, and changes made without `cfgWe` are ignored.
- R11: In a cycle after `inValid` was low, `outWord` keeps its previous value and `outValid` and `outOvf` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Loads the configuration fields |
| cfgMode | input | 2 | Characteristic: 0 round, 1 floor, 2 midriser, 3 magnitude truncation |
| cfgSym | input | 1 | Symmetric clipping option |
| inValid | input | 1 | Input sample qualifier |
| inSample | input | IN_W | Two's-complement input sample |
| outValid | output | 1 | Output qualifier, one cycle after `inValid` |
| outWord | output | OUT_W+1 | Shortened sample |
| outOvf | output | 1 | Output sample was clipped |

## Verification
Errors in the configuration register or in the mode select would show up at once: the next accepted sample would come out with a characteristic that does not match the mode that was written. A wrong rounding offset or a wrong shift amount would make outputs disagree with the arithmetic result for specific inputs one cycle later, and ties at exact half steps are the most sensitive points. A fault in the clamp, either in a limit value or in the symmetric lower bound, shows only at the extreme inputs, on both `outWord` and `outOvf`. A fault in the output holding register shows in the idle cycle that follows a sample.

// File: rtl/qz_pkg.sv
package qz_pkg;

  typedef enum logic [1:0] {
    QZ_ROUND    = 2'd0,
    QZ_FLOOR    = 2'd1,
    QZ_MIDRISER = 2'd2,
    QZ_MAGTRUNC = 2'd3
  } qzMode_e;

  typedef struct packed {
    logic load;
    logic selRound;
    logic selFloor;
    logic selMidriser;
    logic selMag;
    logic symClip;
  } qzStrobe_t;

endpackage

// File: rtl/qz_ctrl.sv
module qz_ctrl
  import qz_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgMode,
  input  logic       cfgSym,
  input  logic       inValid,
  output qzStrobe_t  strobe
);

  qzMode_e modeReg;
  logic    symReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= QZ_ROUND;
      symReg  <= 1'b0;
    end else if (cfgWe) begin
      modeReg <= qzMode_e'(cfgMode);
      symReg  <= cfgSym;
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.load        = inValid;
    strobe.symClip     = symReg;
    unique case (modeReg)
      QZ_ROUND:    strobe.selRound    = 1'b1;
      QZ_FLOOR:    strobe.selFloor    = 1'b1;
      QZ_MIDRISER: strobe.selMidriser = 1'b1;
      QZ_MAGTRUNC: strobe.selMag      = 1'b1;
      default:     strobe.selRound    = 1'b1;
    endcase
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> ($stable(modeReg) && $stable(symReg)));

  // R10
  one_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.selRound, strobe.selFloor, strobe.selMidriser, strobe.selMag}) == 1);

endmodule

// File: rtl/qz_datapath.sv
module qz_datapath
  import qz_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  qzStrobe_t         strobe,
  input  logic [IN_W-1:0]   inSample,
  output logic              outValid,
  output logic [OUT_W:0]    outWord,
  output logic              outOvf
);

  localparam int DROP = IN_W - OUT_W;
  localparam int XW   = IN_W + 2;
  localparam logic signed [XW-1:0] HALF  = XW'(2 ** (DROP - 1));
  localparam logic signed [XW-1:0] TOPV  = XW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [XW-1:0] LOWV  = -TOPV - XW'(1);
  localparam logic signed [XW-1:0] LOWS  = -TOPV;

  logic signed [XW-1:0] xExt;
  logic signed [XW-1:0] roundV;
  logic signed [XW-1:0] floorV;
  logic signed [XW-1:0] magV;
  logic signed [XW-1:0] preV;
  logic signed [XW-1:0] lowLim;
  logic signed [XW-1:0] satV;
  logic                 clipped;
  logic [OUT_W:0]       wordNext;

  always_comb begin
    xExt   = XW'(signed'(inSample));
    roundV = (xExt + HALF) >>> DROP;
    floorV = xExt >>> DROP;
    if (xExt[XW-1]) magV = -((-xExt) >>> DROP);
    else            magV = xExt >>> DROP;

    preV = floorV;
    if (strobe.selRound)      preV = roundV;
    else if (strobe.selMag)   preV = magV;

    lowLim = (strobe.symClip && !strobe.selMidriser) ? LOWS : LOWV;

    if (preV > TOPV)        satV = TOPV;
    else if (preV < lowLim) satV = lowLim;
    else                    satV = preV;
    clipped = (satV != preV);

    if (strobe.selMidriser) wordNext = {satV[OUT_W-1:0], 1'b1};
    else                    wordNext = satV[OUT_W:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outOvf   <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= strobe.load;
      outOvf   <= strobe.load & clipped;
      if (strobe.load) outWord <= wordNext;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  // R2
  ovf_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    outOvf |-> outValid);

  // R5
  midriser_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.selMidriser) |=> outWord[0]);

  // R8
  sym_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.symClip && !strobe.selMidriser)
      |=> (outWord != {1'b1, 1'b1, {(OUT_W-1){1'b0}}}));

  // R9
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.selMidriser) |=> (outWord[OUT_W] == outWord[OUT_W-1]));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(outWord) && !outValid));

endmodule

// File: rtl/qz_top.sv
module qz_top
  import qz_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgMode,
  input  logic             cfgSym,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inSample,
  output logic             outValid,
  output logic [OUT_W:0]   outWord,
  output logic             outOvf
);

  qzStrobe_t strobe;

  qz_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgMode (cfgMode),
    .cfgSym  (cfgSym),
    .inValid (inValid),
    .strobe  (strobe)
  );

  qz_datapath #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inSample (inSample),
    .outValid (outValid),
    .outWord  (outWord),
    .outOvf   (outOvf)
  );

endmodule

// File: tb/qz_top_bench.sv
`timescale 1ns/1ps
module qz_top_bench;

  localparam int IN_W  = 8;
  localparam int OUT_W = 4;
  localparam int DROP  = IN_W - OUT_W;
  localparam int TOPV  = 2 ** (OUT_W - 1) - 1;
  localparam int WMASK = 2 ** (OUT_W + 1) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [1:0]       cfgMode = 2'd0;
  logic             cfgSym = 1'b0;
  logic             inValid = 1'b0;
  logic [IN_W-1:0]  inSample = '0;
  logic             outValid;
  logic [OUT_W:0]   outWord;
  logic             outOvf;

  int nChecks = 0;
  int nFails  = 0;
  int lastWord = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  qz_top #(.IN_W(IN_W), .OUT_W(OUT_W)) u_qz_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgSym(cfgSym),
    .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outWord(outWord), .outOvf(outOvf)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int floorDiv(input int x);
    return x >>> DROP;
  endfunction

  // expected value and clip flag for mode m, symmetric option s
  task automatic model(input int m, input int s, input int x,
                       output int word, output int ovf);
    int pre, lo, sat;
    case (m)
      0: pre = floorDiv(x + 2 ** (DROP - 1));
      1: pre = floorDiv(x);
      2: pre = floorDiv(x);
      default: pre = (x < 0) ? -((-x) >>> DROP) : (x >>> DROP);
    endcase
    lo  = (s != 0 && m != 2) ? -TOPV : -TOPV - 1;
    sat = (pre > TOPV) ? TOPV : ((pre < lo) ? lo : pre);
    ovf = (sat != pre) ? 1 : 0;
    word = (m == 2) ? ((2 * sat + 1) & WMASK) : (sat & WMASK);
  endtask

  task automatic writeCfg(input int m, input int s);
    @(negedge clk);
    cfgWe = 1'b1; cfgMode = 2'(m); cfgSym = 1'(s);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sweep(input int m, input int s);
    string tag;
    int ew, eo;
    case (m)
      0: tag = "R3";
      1: tag = "R4";
      2: tag = "R5";
      default: tag = "R6";
    endcase
    @(negedge clk);
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x++) begin
      inValid = 1'b1;
      inSample = IN_W'(x);
      @(negedge clk);
      model(m, s, x, ew, eo);
      check("R2 outValid", int'(outValid), 1);
      check((s != 0) ? {tag, "/R8 word"} : {tag, "/R9 word"}, int'(outWord), ew);
      check("R7 outOvf", int'(outOvf), eo);
      lastWord = ew;
    end
    inValid = 1'b0;
  endtask

  initial begin
    int ew, eo;
    #1;
    check("R1 reset outValid", int'(outValid), 0);
    check("R1 reset outWord", int'(outWord), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle outValid", int'(outValid), 0);
    check("R1 idle outOvf", int'(outOvf), 0);
    check("R1 idle outWord", int'(outWord), 0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        writeCfg(m, s);
        sweep(m, s);
        @(negedge clk);
        check("R11 outValid idle", int'(outValid), 0);
        check("R11 outOvf idle", int'(outOvf), 0);
        check("R11 outWord held", int'(outWord), lastWord);
      end
    end

    // R6 zero band explicit check in magnitude mode
    writeCfg(3, 0);
    @(negedge clk);
    inValid = 1'b1; inSample = IN_W'(-(2 ** DROP - 1));
    @(negedge clk);
    check("R6 zero band", int'(outWord), 0);
    inValid = 1'b0;

    // R3 tie toward +inf: -8 rounds to 0, +8 to 1
    writeCfg(0, 0);
    @(negedge clk);
    inValid = 1'b1; inSample = IN_W'(-(2 ** (DROP - 1)));
    @(negedge clk);
    check("R3 tie negative", int'(outWord), 0);
    inSample = IN_W'(2 ** (DROP - 1));
    @(negedge clk);
    check("R3 tie positive", int'(outWord), 1);
    inValid = 1'b0;

    // R10 cfg change without write enable is ignored (mode stays 3)
    writeCfg(3, 1);
    @(negedge clk);
    cfgMode = 2'd0; cfgSym = 1'b0;
    @(negedge clk);
    inValid = 1'b1; inSample = IN_W'(2 ** (DROP - 1));
    @(negedge clk);
    model(3, 1, 2 ** (DROP - 1), ew, eo);
    check("R10 ignored cfg word", int'(outWord), ew);
    inSample = IN_W'(-(2 ** (IN_W - 1)));
    @(negedge clk);
    model(3, 1, -(2 ** (IN_W - 1)), ew, eo);
    check("R10 ignored cfg sym word", int'(outWord), ew);
    check("R10 ignored cfg sym ovf", int'(outOvf), eo);
    inValid = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule